// File: doc/BRIEF.md
# Immediate Widening and Scaling Unit

This unit turns a 16-bit immediate into a 32-bit operand with no clock and no stored state. One control bit picks how the upper half is filled. When the bit is low the upper half is zero. When it is high the upper half repeats the immediate's most significant bit. A second control bit multiplies the widened value by four, which produces word-aligned branch displacements.

The fill for the upper half is formed by ANDing the immediate's top bit with the sign control. A sign-enabled request with a non-negative immediate therefore fills with zeros, the same as zero extension. Scaling is a fixed two-place left shift applied after widening. The two lowest result bits become zero and the two highest widened bits are lost. The result is the widened value times four, modulo 2^32.

Top module: `imm_widen_unit`

## Requirements
- R1: With scaling off, result bits 15..0 equal the immediate bits 15..0 in both fill modes.
- R2: With scaling off and the sign control low, result bits 31..16 are all zero for any immediate, including one whose bit 15 is set.
- R3: With scaling off, the sign control high and immediate bit 15 set, result bits 31..16 are all one.
- R4: With scaling off, the sign control high and immediate bit 15 clear, result bits 31..16 are all zero.
- R5: With scaling on, result bits 1..0 are zero and result bit i+2 equals widened bit i for i from 0 to 29. The result equals the widened value times four, modulo 2^32.
- R6: With scaling on, widened bits 31 and 30 are discarded. For example, immediate 16'h8000 with the sign control high gives 32'hFFFE_0000, and immediate 16'hFFFF with the sign control low gives 32'h0003_FFFC.
- R7: The result follows a change of any input without a clock edge. A new input value is reflected one nanosecond later, and no earlier input affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_i | input | 16 | Immediate field to be widened |
| sign_en_i | input | 1 | 1: fill upper half from imm_i[15]; 0: fill with zeros |
| scale_en_i | input | 1 | 1: shift the widened value left by two |
| value_o | output | 32 | Widened and optionally scaled result |

## Verification
The hardest cases are those where the sign control is high but the fill must still be zero, and those where scaling throws away set upper bits. Random immediates reach these only as often as bit 15 happens to take each value. The stimulus therefore runs all four control combinations against 16'h0000, 16'h7FFF, 16'h8000 and 16'hFFFF before the seeded random sweep. Inputs change back to back with no clock edge between them, so a stale value would show up as a mismatch.

// File: rtl/imm_widen_unit.sv
module imm_widen_unit #(
  parameter int IMM_W = 16,
  parameter int OUT_W = 32,
  parameter int SHAMT = 2
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sign_en_i,
  input  logic             scale_en_i,
  output logic [OUT_W-1:0] value_o
);
  localparam int FILL_W = OUT_W - IMM_W;

  logic             fill_bit;
  logic [OUT_W-1:0] widened;
  logic [OUT_W-1:0] scaled;

  assign fill_bit = imm_i[IMM_W-1] & sign_en_i;
  assign widened  = {{FILL_W{fill_bit}}, imm_i};
  assign scaled   = {widened[OUT_W-SHAMT-1:0], {SHAMT{1'b0}}};
  assign value_o  = scale_en_i ? scaled : widened;
endmodule

module imm_widen_unit_chk (
  input logic [15:0] imm_i,
  input logic        sign_en_i,
  input logic        scale_en_i,
  input logic [31:0] value_o
);
  always_comb begin
    if (!scale_en_i) begin
      // R1
      low_pass_chk: assert (value_o[15:0] == imm_i);
      // R2
      zero_fill_chk: assert (sign_en_i || value_o[31:16] == 16'h0000);
      // R3
      sign_fill_chk: assert (!(sign_en_i && imm_i[15]) || $countones(value_o[31:16]) == 16);
      // R4
      pos_fill_chk: assert (!(sign_en_i && !imm_i[15]) || value_o[31:16] == 16'h0000);
    end else begin
      // R5
      low_zero_chk: assert (value_o[1:0] == 2'b00);
      // R5
      shift_pass_chk: assert (value_o[17:2] == imm_i);
      // R6
      upper_fill_chk: assert ($countones(value_o[31:18]) == ((sign_en_i && imm_i[15]) ? 14 : 0));
    end
  end
endmodule

bind imm_widen_unit imm_widen_unit_chk u_chk (
  .imm_i(imm_i), .sign_en_i(sign_en_i), .scale_en_i(scale_en_i), .value_o(value_o)
);

// File: tb/imm_widen_unit_tb.sv
`timescale 1ns/1ps
module imm_widen_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm = 16'h0000;
  logic        sgn = 1'b0;
  logic        scl = 1'b0;
  logic [31:0] res;
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  imm_widen_unit u_dut (
    .imm_i(imm), .sign_en_i(sgn), .scale_en_i(scl), .value_o(res)
  );

  function automatic logic [31:0] model(input logic [15:0] v, input logic s, input logic k);
    logic [31:0] w;
    if (s && v[15]) w = 32'hFFFF_0000 | {16'h0000, v};
    else            w = {16'h0000, v};
    return k ? w * 32'd4 : w;
  endfunction

  function automatic string tag(input logic [15:0] v, input logic s, input logic k);
    if (k) return (v[15] && s) || v[15:14] != 2'b00 ? "R6" : "R5";
    if (!s) return "R2";
    return v[15] ? "R3" : "R4";
  endfunction

  task automatic apply(input logic [15:0] v, input logic s, input logic k, input string r);
    logic [31:0] exp;
    imm = v; sgn = s; scl = k;
    #1;
    exp = model(v, s, k);
    n_cmp++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s imm=%h sgn=%b scl=%b actual=%h expected=%h", r, v, s, k, res, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [4];
    int seed;
    corners[0] = 16'h0000; corners[1] = 16'h7FFF;
    corners[2] = 16'h8000; corners[3] = 16'hFFFF;
    seed = $urandom(32'h1D5E_0007);
    #2;
    // R1: all-zero inputs give zero
    apply(16'h0000, 1'b0, 1'b0, "R1");
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 4; m++) begin
        apply(corners[c], m[0], m[1], tag(corners[c], m[0], m[1]));
      end
    end
    // R6: named examples
    apply(16'h8000, 1'b1, 1'b1, "R6");
    apply(16'hFFFF, 1'b0, 1'b1, "R6");
    // R7: back-to-back changes without a clock edge between them
    @(negedge clk);
    apply(16'h8001, 1'b1, 1'b0, "R7");
    apply(16'h8001, 1'b0, 1'b0, "R7");
    apply(16'h1234, 1'b0, 1'b1, "R7");
    // R1 and the mode checks over a seeded random sweep
    for (int i = 0; i < 600; i++) begin
      logic [15:0] v;
      logic [1:0]  m;
      v = 16'($urandom());
      m = 2'($urandom());
      if (i % 8 == 0) @(negedge clk);
      apply(v, m[0], m[1], m[1] ? tag(v, m[0], m[1]) : "R1");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule